// File: doc/BRIEF.md
# Z80 I/O to Sound-Generator Bus Adapter

This block sits between the I/O side of a Z80-style processor and a programmable sound generator. The sound generator has a shared 8-bit bus that carries both the register address and the data. It is steered by a two-wire control pair: a direction line (`psg_bdir`) and a control line (`psg_bc1`). A CPU output cycle becomes one of two stretched operations on the sound-generator bus: a register-select (latch address) or a register write. The choice depends on address bit A0. A CPU input cycle becomes a register read. Memory cycles and interrupt-acknowledge cycles never reach the sound generator.

The processor's strobes are short compared with the generator's timing needs. The adapter therefore synchronises the strobes into a system clock and captures the CPU data as it stood when the write strobe rose. It then drives the generator from its own latch. The active control code is held for the minimum write duration, and the data stays on the bus for the required hold time. Read data from the generator is sampled into a register, and the CPU bus is driven only through an enable that follows the live read strobe.

All durations are counted in cycles of the system clock, using ceil(ns × `CLK_HZ` / 1e9). A write that arrives while an operation is in progress waits in a one-entry holding slot. Losing a write because that slot is already full sets a sticky overrun flag.

The control state machine has four states:
- `ST_IDLE`: inactive code.
- `ST_STRETCH`: active write code.
- `ST_HOLD`: inactive code with data still driven.
- `ST_READ`: read code.

The transitions are:
- Idle→stretch when a queued or new write is present; a queued write wins.
- Idle→read when a qualified read strobe is seen.
- Stretch→hold when the duration counter expires.
- Hold→idle when the hold counter expires.
- Read→idle when the read strobe or the I/O select ends.

Top module: `psg_bus_adapter`

## Requirements
- R1: The control pair is coded {bdir,bc1}: 00 inactive, 01 read, 10 data write, 11 latch address. A qualified write with A0=1 produces 11, a qualified write with A0=0 produces 10, and a qualified read produces 01.
- R2: A strobe seen while `z_iorq_n` is high or `z_m1_n` is low produces no sound-generator operation. The control pair stays 00, `busy` stays low and `cpu_d_oe` stays low.
- R3: The value driven on `psg_da_out` is the CPU data present while WR was still low before its rising edge. A change of the CPU bus at or after that edge has no effect.
- R4: The active write code (10 or 11) is held for exactly WR_CYC = ceil(1950 ns × CLK_HZ / 1e9) cycles, which is 244 at 125 MHz.
- R5: After the active write code, the pair returns to 00 while `psg_da_oe` stays high and `psg_da_out` stays stable. This lasts ceil(400 ns × f) cycles (50 at 125 MHz) after a data write and ceil(50 ns × f) cycles (7) after an address write.
- R6: The control pair never changes directly from one non-zero code to another; 00 always lies between two operations.
- R7: `cpu_d_oe` is high only while `z_rd_n` is low, `z_iorq_n` is low and `z_m1_n` is high. It drops in the same cycle that `z_rd_n` rises.
- R8: During a read, code 01 is present only while the synchronised read select is active. The generator's data is sampled one cycle after the read state is entered and is presented on `cpu_d_out`.
- R9: `busy` is high throughout the active write and hold intervals, and no read code appears while busy.
- R10: A qualified write that arrives while busy is held in a one-entry slot and executed, with its own code and value, after the current operation.
- R11: A qualified write that arrives while the slot is full is dropped and sets `overrun`, which stays high until reset.
- R12: After reset the control pair is 00, and `busy`, `overrun`, `psg_da_oe` and `cpu_d_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| z_iorq_n | input | 1 | CPU I/O request, active low |
| z_m1_n | input | 1 | CPU opcode-fetch / acknowledge marker, active low |
| z_wr_n | input | 1 | CPU write strobe, active low |
| z_rd_n | input | 1 | CPU read strobe, active low |
| z_a0 | input | 1 | CPU address bit 0, selects address or data |
| z_d_in | input | DW | CPU data bus, write direction |
| cpu_d_out | output | DW | Read data toward the CPU |
| cpu_d_oe | output | 1 | Tristate enable toward the CPU bus |
| psg_bdir | output | 1 | Sound-generator direction control |
| psg_bc1 | output | 1 | Sound-generator bus control |
| psg_da_out | output | DW | Latched value driven onto the generator bus |
| psg_da_oe | output | 1 | Drive enable for the generator bus |
| psg_da_in | input | DW | Generator bus, read direction |
| busy | output | 1 | Write or hold interval in progress |
| overrun | output | 1 | Sticky: a write was lost |

## Verification
The hardest situation to reach is the overrun. It needs three qualified writes to land inside one stretched write, with the second still waiting in the slot when the third arrives. The bench issues three complete CPU write cycles back to back, about eight clocks each, while the first write's 244-cycle stretch is still running. It then checks that the second write, not the third, is the one executed next. Capturing data at the WR edge is exercised by flipping the CPU bus in the same cycle that WR rises, for every value in the sweep.

// File: rtl/psg_bridge_pkg.sv
package psg_bridge_pkg;

    typedef enum logic [1:0] {
        CODE_IDLE = 2'b00,
        CODE_READ = 2'b01,
        CODE_DATA = 2'b10,
        CODE_ADDR = 2'b11
    } psg_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STRETCH,
        ST_HOLD,
        ST_READ
    } bridge_st_e;

    function automatic int ns_to_cycles(input longint ns, input longint hz);
        return int'((ns * hz + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/psg_sync2.sv
module psg_sync2 #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/psg_dur_cnt.sv
module psg_dur_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/psg_bus_adapter.sv
module psg_bus_adapter
    import psg_bridge_pkg::*;
#(
    parameter longint CLK_HZ       = 125_000_000,
    parameter int     DW           = 8,
    parameter int     WRITE_NS     = 1950,
    parameter int     DATA_HOLD_NS = 400,
    parameter int     ADDR_HOLD_NS = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          z_iorq_n,
    input  logic          z_m1_n,
    input  logic          z_wr_n,
    input  logic          z_rd_n,
    input  logic          z_a0,
    input  logic [DW-1:0] z_d_in,
    output logic [DW-1:0] cpu_d_out,
    output logic          cpu_d_oe,
    output logic          psg_bdir,
    output logic          psg_bc1,
    output logic [DW-1:0] psg_da_out,
    output logic          psg_da_oe,
    input  logic [DW-1:0] psg_da_in,
    output logic          busy,
    output logic          overrun
);
    localparam int WR_CYC  = ns_to_cycles(longint'(WRITE_NS), CLK_HZ);
    localparam int DH_CYC  = ns_to_cycles(longint'(DATA_HOLD_NS), CLK_HZ);
    localparam int AH_CYC  = ns_to_cycles(longint'(ADDR_HOLD_NS), CLK_HZ);
    localparam int MAX_CYC = (WR_CYC > DH_CYC) ? ((WR_CYC > AH_CYC) ? WR_CYC : AH_CYC)
                                               : ((DH_CYC > AH_CYC) ? DH_CYC : AH_CYC);
    localparam int CW      = $clog2(MAX_CYC + 2);
    localparam int PIPE    = 3;
    localparam int CAPW    = DW + 2;

    // Strobe synchronisers: {rd_n, wr_n, iorq_n, m1_n}
    logic [3:0] strb_s;
    psg_sync2 #(.W(4), .RST_VAL(4'b1111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({z_rd_n, z_wr_n, z_iorq_n, z_m1_n}),
        .q(strb_s)
    );
    logic rd_s, wr_s, iorq_s, m1_s, wr_q;
    assign {rd_s, wr_s, iorq_s, m1_s} = strb_s;

    // Capture pipeline aligned with the synchroniser: {select, a0, data}
    logic [CAPW-1:0] cap_pipe [PIPE];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PIPE; i++) cap_pipe[i] <= '0;
            wr_q <= 1'b1;
        end else begin
            cap_pipe[0] <= {(!z_iorq_n && z_m1_n), z_a0, z_d_in};
            for (int i = 1; i < PIPE; i++) cap_pipe[i] <= cap_pipe[i-1];
            wr_q <= wr_s;
        end
    end

    logic          wr_rise, new_req, new_addr, rd_go;
    logic [DW-1:0] new_val;
    assign wr_rise  = wr_s && !wr_q;
    assign new_req  = wr_rise && cap_pipe[PIPE-1][DW+1];
    assign new_addr = cap_pipe[PIPE-1][DW];
    assign new_val  = cap_pipe[PIPE-1][DW-1:0];
    assign rd_go    = !rd_s && !iorq_s && m1_s;

    // State and request registers
    bridge_st_e    state, state_nx;
    logic          q_valid, q_addr, act_addr, rd_taken;
    logic [DW-1:0] q_val, act_val, rd_data;
    logic          q_take, direct, to_q, cnt_zero, cnt_load;
    logic [CW-1:0] cnt_val;

    assign q_take = (state == ST_IDLE) && q_valid;
    assign direct = (state == ST_IDLE) && !q_valid && new_req;
    assign to_q   = new_req && !direct;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (q_valid || new_req) state_nx = ST_STRETCH;
                else if (rd_go)         state_nx = ST_READ;
            end
            ST_STRETCH: if (cnt_zero) state_nx = ST_HOLD;
            ST_HOLD:    if (cnt_zero) state_nx = ST_IDLE;
            ST_READ:    if (!rd_go)   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        if (state == ST_IDLE && state_nx == ST_STRETCH) begin
            cnt_load = 1'b1;
            cnt_val  = CW'(WR_CYC - 1);
        end else if (state == ST_STRETCH && state_nx == ST_HOLD) begin
            cnt_load = 1'b1;
            cnt_val  = act_addr ? CW'(AH_CYC - 1) : CW'(DH_CYC - 1);
        end
    end

    psg_dur_cnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            q_valid  <= 1'b0;
            q_addr   <= 1'b0;
            q_val    <= '0;
            act_addr <= 1'b0;
            act_val  <= '0;
            overrun  <= 1'b0;
            rd_data  <= '0;
            rd_taken <= 1'b0;
        end else begin
            state <= state_nx;
            if (q_take) begin
                act_addr <= q_addr;
                act_val  <= q_val;
                q_valid  <= 1'b0;
            end else if (direct) begin
                act_addr <= new_addr;
                act_val  <= new_val;
            end
            if (to_q) begin
                if (q_valid && !q_take) begin
                    overrun <= 1'b1;
                end else begin
                    q_valid <= 1'b1;
                    q_addr  <= new_addr;
                    q_val   <= new_val;
                end
            end
            if (state == ST_READ) begin
                if (!rd_taken) begin
                    rd_data  <= psg_da_in;
                    rd_taken <= 1'b1;
                end
            end else begin
                rd_taken <= 1'b0;
            end
        end
    end

    // Output decode
    psg_code_e code;
    always_comb begin
        code      = CODE_IDLE;
        psg_da_oe = 1'b0;
        busy      = 1'b0;
        unique case (state)
            ST_IDLE:    code = CODE_IDLE;
            ST_STRETCH: begin
                code      = act_addr ? CODE_ADDR : CODE_DATA;
                psg_da_oe = 1'b1;
                busy      = 1'b1;
            end
            ST_HOLD: begin
                psg_da_oe = 1'b1;
                busy      = 1'b1;
            end
            ST_READ:    code = CODE_READ;
        endcase
    end

    assign {psg_bdir, psg_bc1} = code;
    assign psg_da_out = act_val;
    assign cpu_d_out  = rd_data;
    assign cpu_d_oe   = !z_rd_n && !z_iorq_n && z_m1_n;

    // Checker state and assertions
    logic [CW-1:0] act_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         act_len <= '0;
        else if (psg_bdir)  act_len <= act_len + 1'b1;
        else                act_len <= '0;
    end

    AST_WRITE_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psg_bdir) |-> (act_len >= CW'(WR_CYC))); // R4

    AST_CODE_VIA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past({psg_bdir, psg_bc1}) != 2'b00 && {psg_bdir, psg_bc1} != $past({psg_bdir, psg_bc1}))
        |-> ({psg_bdir, psg_bc1} == 2'b00)); // R6

    AST_HOLD_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (psg_da_oe && $past(psg_da_oe)) |-> $stable(psg_da_out)); // R5

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R11

    AST_READ_ONLY_WITH_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (!psg_bdir && psg_bc1) |-> $past(rd_go)); // R8

    AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(!psg_bdir && psg_bc1)); // R9
endmodule

// File: tb/psg_bus_adapter_tb_top.sv
module psg_bus_adapter_tb_top;
    localparam int DW     = 8;
    localparam int MHZ    = 125;
    localparam int WR_EXP = (1950 * MHZ + 999) / 1000;
    localparam int DH_EXP = (400 * MHZ + 999) / 1000;
    localparam int AH_EXP = (50 * MHZ + 999) / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic z_iorq_n = 1'b1, z_m1_n = 1'b1, z_wr_n = 1'b1, z_rd_n = 1'b1, z_a0 = 1'b0;
    logic [DW-1:0] z_d_in = '0, psg_da_in = '0;
    logic [DW-1:0] cpu_d_out, psg_da_out;
    logic cpu_d_oe, psg_bdir, psg_bc1, psg_da_oe, busy, overrun;

    int checks = 0, failures = 0, direct_sw = 0;
    bit done = 1'b0;
    logic [1:0] prev_code = 2'b00;

    always #4 clk = ~clk;

    psg_bus_adapter #(.CLK_HZ(125_000_000), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .z_iorq_n(z_iorq_n), .z_m1_n(z_m1_n), .z_wr_n(z_wr_n), .z_rd_n(z_rd_n),
        .z_a0(z_a0), .z_d_in(z_d_in),
        .cpu_d_out(cpu_d_out), .cpu_d_oe(cpu_d_oe),
        .psg_bdir(psg_bdir), .psg_bc1(psg_bc1),
        .psg_da_out(psg_da_out), .psg_da_oe(psg_da_oe), .psg_da_in(psg_da_in),
        .busy(busy), .overrun(overrun)
    );

    // R6 monitor: count direct switches between two non-zero codes
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_code != 2'b00 && {psg_bdir, psg_bc1} != 2'b00 &&
                {psg_bdir, psg_bc1} != prev_code)
                direct_sw++;
            prev_code = {psg_bdir, psg_bc1};
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input bit sel_ok, input bit m1_n, input bit a0, input logic [DW-1:0] v);
        @(negedge clk);
        z_iorq_n = !sel_ok; z_m1_n = m1_n; z_a0 = a0; z_d_in = v;
        @(negedge clk);
        z_wr_n = 1'b0;
        repeat (6) @(negedge clk);
        z_wr_n = 1'b1;
        z_d_in = ~v;               // bus changes at the WR edge (R3)
        @(negedge clk);
        z_iorq_n = 1'b1; z_m1_n = 1'b1; z_d_in = 8'h3C;
    endtask

    task automatic observe_write(input bit a0, input logic [DW-1:0] v, input string tag);
        int n = 0, h = 0, w = 0, bad = 0;
        while (!psg_bdir && w < 600) begin @(negedge clk); w++; end
        check(psg_bdir == 1'b1, {tag, " R1 write code appears"}, psg_bdir, 1);
        check(psg_bc1 == a0, {tag, " R1 bc1 follows A0"}, psg_bc1, a0);
        check(psg_da_out == v, {tag, " R3 captured value"}, psg_da_out, v);
        while (psg_bdir && n < 1000) begin
            if (!busy || !psg_da_oe) bad++;
            @(negedge clk); n++;
        end
        check(n == WR_EXP, {tag, " R4 active length"}, n, WR_EXP);
        while (busy && h < 1000) begin
            if ({psg_bdir, psg_bc1} != 2'b00 || !psg_da_oe || psg_da_out != v) bad++;
            @(negedge clk); h++;
        end
        check(h == (a0 ? AH_EXP : DH_EXP), {tag, " R5 hold length"}, h, a0 ? AH_EXP : DH_EXP);
        check(bad == 0, {tag, " R9 busy/data during write"}, bad, 0);
    endtask

    initial begin : stim
        repeat (3) @(negedge clk);
        check({psg_bdir, psg_bc1} == 2'b00 && !busy && !overrun && !psg_da_oe && !cpu_d_oe,
              "R12 reset state", {psg_bdir, psg_bc1, busy, overrun}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Sweep of address and data writes
        for (int i = 0; i < 16; i++) begin
            logic [DW-1:0] v;
            v = DW'(i * 37 + 5);
            cpu_write(1'b1, 1'b1, 1'b1, v);
            observe_write(1'b1, v, "addr");
            cpu_write(1'b1, 1'b1, 1'b0, ~v);
            observe_write(1'b0, ~v, "data");
        end

        // R2: rejected cycles
        for (int k = 0; k < 2; k++) begin
            int act = 0;
            if (k == 0) cpu_write(1'b0, 1'b1, 1'b1, 8'hA5);
            else        cpu_write(1'b1, 1'b0, 1'b0, 8'hA5);
            repeat (20) begin
                if (psg_bdir || psg_bc1 || busy) act++;
                @(negedge clk);
            end
            check(act == 0, "R2 rejected write", act, 0);
        end
        @(negedge clk);
        z_iorq_n = 1'b0; z_m1_n = 1'b0; z_rd_n = 1'b0;
        repeat (8) @(negedge clk);
        check(!cpu_d_oe && !psg_bc1 && !psg_bdir, "R2 rejected read", {cpu_d_oe, psg_bc1}, 0);
        z_iorq_n = 1'b1; z_m1_n = 1'b1; z_rd_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7/R8: read sweep
        for (int i = 0; i < 8; i++) begin
            logic [DW-1:0] v;
            v = DW'(i * 53 + 9);
            psg_da_in = v;
            z_iorq_n = 1'b0; z_rd_n = 1'b0;
            #1;
            check(cpu_d_oe == 1'b1, "R7 oe with read", cpu_d_oe, 1);
            repeat (8) @(negedge clk);
            check({psg_bdir, psg_bc1} == 2'b01, "R8 read code", {psg_bdir, psg_bc1}, 1);
            check(cpu_d_out == v, "R8 read data", cpu_d_out, v);
            psg_da_in = ~v;
            z_rd_n = 1'b1;
            #1;
            check(cpu_d_oe == 1'b0, "R7 oe drops with RD", cpu_d_oe, 0);
            @(negedge clk);
            z_iorq_n = 1'b1;
            repeat (4) @(negedge clk);
            check({psg_bdir, psg_bc1} == 2'b00, "R1 read ends inactive", {psg_bdir, psg_bc1}, 0);
            check(cpu_d_out == v, "R8 read data held", cpu_d_out, v);
        end

        // R10: queued write
        cpu_write(1'b1, 1'b1, 1'b1, 8'h11);
        cpu_write(1'b1, 1'b1, 1'b0, 8'h22);
        check(busy == 1'b1, "R9 busy during stretch", busy, 1);
        while (psg_bdir) @(negedge clk);
        observe_write(1'b0, 8'h22, "R10 queued");
        check(overrun == 1'b0, "R11 no overrun yet", overrun, 0);

        // R11: overrun
        cpu_write(1'b1, 1'b1, 1'b0, 8'h44);
        cpu_write(1'b1, 1'b1, 1'b1, 8'h55);
        cpu_write(1'b1, 1'b1, 1'b0, 8'h66);
        repeat (5) @(negedge clk);
        check(overrun == 1'b1, "R11 overrun set", overrun, 1);
        while (psg_bdir) @(negedge clk);
        observe_write(1'b1, 8'h55, "R11 second kept");
        repeat (20) @(negedge clk);
        check(!busy && {psg_bdir, psg_bc1} == 2'b00, "R11 third dropped", busy, 0);
        check(overrun == 1'b1, "R11 overrun sticky", overrun, 1);

        check(direct_sw == 0, "R6 no direct code switch", direct_sw, 0);
        done = 1'b1;
    end

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 190_000) begin @(negedge clk); cyc++; end
        if (!done) check(1'b0, "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule